// File: doc/BRIEF.md
# Dual Wiper Register Bank Executor

This block keeps the digital state of two digitally controlled potentiometers. Each pot owns a volatile wiper code, which sets the tap of its resistor ladder (code 0x00 is the low end, the all-ones code is the high end), and four data registers that model slow nonvolatile storage. A serial front end decodes each bus transaction into an opcode, a register index, a pot index and a data byte. It presents them together with a one-cycle execute strobe. The block then reads, writes or moves values between the wipers and the data registers, one pot at a time or for both pots in one step.

Any change to a data register is timed as a nonvolatile write. A busy flag stays high for a parameterised number of clocks, and commands that arrive during that window are dropped. A write-protect input, active low, blocks every change to the data registers. Reset stands in for power-up: each wiper reloads from data register 0 of its own pot. The data registers keep their contents across reset, and their values at configuration time come from a parameter.

Top module: `dual_wiper_bank`

## Requirements
- R1: While reset is held, and in the first cycle after it, each wiper equals data register 0 of its pot, with busy and rd_valid low. This also holds after data register 0 has been rewritten.
- R2: Opcode 4'b1010 loads cmd_data into the wiper chosen by cmd_pot, visible one cycle after the strobe, without raising busy.
- R3: Opcode 4'b1001 returns the chosen wiper, and opcode 4'b1011 returns data register cmd_reg of pot cmd_pot. rd_valid pulses and rd_data holds the value one cycle after the strobe.
- R4: Opcode 4'b1100 stores cmd_data in data register cmd_reg of pot cmd_pot.
- R5: Opcode 4'b1101 copies data register cmd_reg of the chosen pot into its wiper. Opcode 4'b0001 does so for both pots at once, ignoring cmd_pot. Neither raises busy.
- R6: Opcode 4'b1110 copies the chosen wiper into data register cmd_reg of its pot. Opcode 4'b1000 does so for both pots at once, ignoring cmd_pot.
- R7: Opcode 4'b0010 moves the chosen wiper one step up when cmd_up is 1 and one step down when it is 0. The wiper holds at all-ones going up and at zero going down.
- R8: While wp_n is low, opcodes 4'b1100, 4'b1110 and 4'b1000 leave every data register unchanged and do not raise busy.
- R9: An accepted data-register write raises busy for exactly NV_WRITE_CYCLES cycles, starting the cycle after the strobe.
- R10: A strobe seen while busy is high is dropped: no read response, no wiper change and no data-register change.
- R11: A strobe with any other opcode changes no wiper or data register and raises neither busy nor rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; triggers the wiper recall |
| cmd_valid | input | 1 | Execute strobe for the command on the cmd_* inputs |
| cmd_op | input | 4 | Opcode |
| cmd_reg | input | SEL_W | Data register index |
| cmd_pot | input | POT_W | Pot index |
| cmd_data | input | CODE_W | Data byte for write opcodes |
| cmd_up | input | 1 | Step direction for opcode 4'b0010 (1 = toward the high end) |
| wp_n | input | 1 | Write enable for data registers; low blocks changes |
| busy | output | 1 | Nonvolatile write in progress; commands are dropped |
| rd_valid | output | 1 | One-cycle read response strobe |
| rd_data | output | CODE_W | Read response value |
| wiper_code | output | NUM_POTS*CODE_W | Wiper codes, pot p in bits [p*CODE_W +: CODE_W] |

## Verification
On every cycle the assertions check the following. Busy rises only after a strobe made while wp_n was high. Each busy run lasts exactly the programmed length. Busy cannot start while protection is on. A strobe during busy neither changes a wiper nor yields a read response. A step past either end leaves the wiper unchanged. Every read response follows a strobe. The bench scenarios are needed for the data itself: the value a read returns, the contents of the data registers after single and global transfers and after blocked or dropped writes, and the recall of a rewritten data register 0 at reset.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

   typedef enum logic [3:0] {
      OP_GXFR_DR2W = 4'b0001,
      OP_STEP      = 4'b0010,
      OP_GXFR_W2DR = 4'b1000,
      OP_RD_WIPER  = 4'b1001,
      OP_WR_WIPER  = 4'b1010,
      OP_RD_DR     = 4'b1011,
      OP_WR_DR     = 4'b1100,
      OP_XFR_DR2W  = 4'b1101,
      OP_XFR_W2DR  = 4'b1110
   } op_e;

   typedef struct packed {
      logic rd_wiper;
      logic rd_dr;
      logic wr_wiper;
      logic wr_dr;
      logic dr2w;
      logic w2dr;
      logic g_dr2w;
      logic g_w2dr;
      logic step;
      logic nv_start;
   } action_t;

endpackage

// File: rtl/dwb_decode.sv
module dwb_decode
   import dwb_pkg::*;
(
   input  logic       cmd_valid,
   input  logic       busy,
   input  logic       wp_n,
   input  logic [3:0] cmd_op,
   output action_t    act
);

   logic accept;
   assign accept = cmd_valid && !busy;

   always_comb begin
      act = '0;
      if (accept) begin
         case (cmd_op)
            OP_RD_WIPER:  act.rd_wiper = 1'b1;
            OP_RD_DR:     act.rd_dr    = 1'b1;
            OP_WR_WIPER:  act.wr_wiper = 1'b1;
            OP_WR_DR:     act.wr_dr    = wp_n;
            OP_XFR_DR2W:  act.dr2w     = 1'b1;
            OP_XFR_W2DR:  act.w2dr     = wp_n;
            OP_GXFR_DR2W: act.g_dr2w   = 1'b1;
            OP_GXFR_W2DR: act.g_w2dr   = wp_n;
            OP_STEP:      act.step     = 1'b1;
            default:      ;
         endcase
      end
      act.nv_start = act.wr_dr | act.w2dr | act.g_w2dr;
   end

endmodule

// File: rtl/dwb_nv_timer.sv
module dwb_nv_timer #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int unsigned CNT_W = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("dwb_nv_timer: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CNT_W'(CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/dwb_pot_slice.sv
module dwb_pot_slice #(
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned NUM_REGS = 4,
   parameter int unsigned SEL_W    = $clog2(NUM_REGS),
   parameter logic [NUM_REGS*CODE_W-1:0] INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              ld_wiper_data,
   input  logic              ld_wiper_dr,
   input  logic              step_en,
   input  logic              step_up,
   input  logic              dr_wr_data,
   input  logic              dr_wr_wiper,
   output logic [CODE_W-1:0] wiper_q,
   output logic [CODE_W-1:0] dr_rd
);

   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

   logic [NUM_REGS*CODE_W-1:0] dr_flat;
   logic                       dr_we;
   logic [CODE_W-1:0]          dr_wd;

   assign dr_we = dr_wr_data | dr_wr_wiper;
   assign dr_wd = dr_wr_wiper ? wiper_q : wr_data;

   // Data registers model nonvolatile cells: no reset, configured start value.
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [CODE_W-1:0] cell_q = INIT[r*CODE_W +: CODE_W];
      always_ff @(posedge clk) begin
         if (dr_we && (reg_sel == SEL_W'(r))) begin
            cell_q <= dr_wd;
         end
      end
      assign dr_flat[r*CODE_W +: CODE_W] = cell_q;
   end

   assign dr_rd = dr_flat[reg_sel*CODE_W +: CODE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wiper_q <= dr_flat[CODE_W-1:0];
      end else if (ld_wiper_data) begin
         wiper_q <= wr_data;
      end else if (ld_wiper_dr) begin
         wiper_q <= dr_rd;
      end else if (step_en) begin
         if (step_up && (wiper_q != CODE_MAX)) begin
            wiper_q <= wiper_q + 1'b1;
         end else if (!step_up && (wiper_q != '0)) begin
            wiper_q <= wiper_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/dual_wiper_bank.sv
module dual_wiper_bank
   import dwb_pkg::*;
#(
   parameter int unsigned NUM_POTS        = 2,
   parameter int unsigned NUM_REGS        = 4,
   parameter int unsigned CODE_W          = 8,
   parameter int unsigned NV_WRITE_CYCLES = 16,
   parameter int unsigned SEL_W           = $clog2(NUM_REGS),
   parameter int unsigned POT_W           = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
   parameter logic [NUM_POTS*NUM_REGS*CODE_W-1:0] DR_INIT = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid,
   input  logic [3:0]                 cmd_op,
   input  logic [SEL_W-1:0]           cmd_reg,
   input  logic [POT_W-1:0]           cmd_pot,
   input  logic [CODE_W-1:0]          cmd_data,
   input  logic                       cmd_up,
   input  logic                       wp_n,
   output logic                       busy,
   output logic                       rd_valid,
   output logic [CODE_W-1:0]          rd_data,
   output logic [NUM_POTS*CODE_W-1:0] wiper_code
);

   localparam int unsigned SLICE_BITS = NUM_REGS * CODE_W;

   if (NUM_POTS < 1 || NUM_REGS < 2 || CODE_W < 2) begin : g_bad_size
      $error("dual_wiper_bank: need NUM_POTS>=1, NUM_REGS>=2, CODE_W>=2");
   end
   if (SEL_W != $clog2(NUM_REGS)) begin : g_bad_sel
      $error("dual_wiper_bank: SEL_W is derived and must not be overridden");
   end
   if (NV_WRITE_CYCLES < 1) begin : g_bad_nv
      $error("dual_wiper_bank: NV_WRITE_CYCLES must be at least 1");
   end

   action_t           act;
   logic [CODE_W-1:0] wip_a  [NUM_POTS];
   logic [CODE_W-1:0] drrd_a [NUM_POTS];
   logic [CODE_W-1:0] rd_next;

   dwb_decode u_decode (
      .cmd_valid (cmd_valid),
      .busy      (busy),
      .wp_n      (wp_n),
      .cmd_op    (cmd_op),
      .act       (act)
   );

   dwb_nv_timer #(.CYCLES(NV_WRITE_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (act.nv_start),
      .busy  (busy)
   );

   for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
      logic sel;
      assign sel = (cmd_pot == POT_W'(p));

      dwb_pot_slice #(
         .CODE_W   (CODE_W),
         .NUM_REGS (NUM_REGS),
         .SEL_W    (SEL_W),
         .INIT     (DR_INIT[p*SLICE_BITS +: SLICE_BITS])
      ) u_slice (
         .clk           (clk),
         .rst_n         (rst_n),
         .reg_sel       (cmd_reg),
         .wr_data       (cmd_data),
         .ld_wiper_data (act.wr_wiper & sel),
         .ld_wiper_dr   ((act.dr2w & sel) | act.g_dr2w),
         .step_en       (act.step & sel),
         .step_up       (cmd_up),
         .dr_wr_data    (act.wr_dr & sel),
         .dr_wr_wiper   ((act.w2dr & sel) | act.g_w2dr),
         .wiper_q       (wip_a[p]),
         .dr_rd         (drrd_a[p])
      );

      assign wiper_code[p*CODE_W +: CODE_W] = wip_a[p];
   end

   always_comb begin
      rd_next = '0;
      for (int p = 0; p < NUM_POTS; p++) begin
         if (cmd_pot == POT_W'(p)) begin
            rd_next = act.rd_wiper ? wip_a[p] : drrd_a[p];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= act.rd_wiper | act.rd_dr;
         if (act.rd_wiper | act.rd_dr) begin
            rd_data <= rd_next;
         end
      end
   end

endmodule

// File: rtl/dwb_checker.sv
module dwb_checker #(
   parameter int unsigned NUM_POTS        = 2,
   parameter int unsigned CODE_W          = 8,
   parameter int unsigned NV_WRITE_CYCLES = 16,
   parameter int unsigned SEL_W           = 2,
   parameter int unsigned POT_W           = 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cmd_valid,
   input logic [3:0]                 cmd_op,
   input logic [SEL_W-1:0]           cmd_reg,
   input logic [POT_W-1:0]           cmd_pot,
   input logic [CODE_W-1:0]          cmd_data,
   input logic                       cmd_up,
   input logic                       wp_n,
   input logic                       busy,
   input logic                       rd_valid,
   input logic [CODE_W-1:0]          rd_data,
   input logic [NUM_POTS*CODE_W-1:0] wiper_code
);

   logic [CODE_W-1:0] cur;
   logic              step_cmd;
   int unsigned       run_cnt;

   always_comb begin
      cur = '0;
      for (int p = 0; p < NUM_POTS; p++) begin
         if (cmd_pot == POT_W'(p)) cur = wiper_code[p*CODE_W +: CODE_W];
      end
   end

   assign step_cmd = cmd_valid && !busy && (cmd_op == 4'b0010);

   always_ff @(posedge clk) begin
      if (!rst_n)    run_cnt <= 0;
      else if (busy) run_cnt <= run_cnt + 1;
      else           run_cnt <= 0;
   end

   AST_READ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(cmd_valid)); // R3

   AST_PROTECT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wp_n) |=> !busy); // R8

   AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cmd_valid) && $past(wp_n))); // R9

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == NV_WRITE_CYCLES)); // R9

   AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !rd_valid); // R10

   AST_BUSY_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> $stable(wiper_code)); // R10

   AST_STEP_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd && cmd_up && (cur == {CODE_W{1'b1}})) |=> $stable(wiper_code)); // R7

   AST_STEP_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd && !cmd_up && (cur == '0)) |=> $stable(wiper_code)); // R7

endmodule

bind dual_wiper_bank dwb_checker #(
   .NUM_POTS        (NUM_POTS),
   .CODE_W          (CODE_W),
   .NV_WRITE_CYCLES (NV_WRITE_CYCLES),
   .SEL_W           (SEL_W),
   .POT_W           (POT_W)
) u_dwb_checker (.*);

// File: tb/tb_dual_wiper_bank.sv
module tb_dual_wiper_bank;

   localparam int NV = 8;
   localparam logic [63:0] DRI = 64'hA7A6A5A4_A3A2A1A0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = '0;
   logic [1:0]  cmd_reg = '0;
   logic [0:0]  cmd_pot = '0;
   logic [7:0]  cmd_data = '0;
   logic        cmd_up = 1'b0;
   logic        wp_n = 1'b1;
   logic        busy;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic [15:0] wiper_code;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] m_dr [2][4];
   logic [7:0] m_wip [2];

   always #5 clk = ~clk;

   dual_wiper_bank #(
      .NUM_POTS(2), .NUM_REGS(4), .CODE_W(8),
      .NV_WRITE_CYCLES(NV), .DR_INIT(DRI)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_reg(cmd_reg), .cmd_pot(cmd_pot), .cmd_data(cmd_data),
      .cmd_up(cmd_up), .wp_n(wp_n), .busy(busy), .rd_valid(rd_valid),
      .rd_data(rd_data), .wiper_code(wiper_code)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // model of the documented behaviour, applied only to commands that are accepted
   task automatic apply(input logic [3:0] op, input int r, input int p,
                        input logic [7:0] d, input logic up);
      case (op)
         4'b1010: m_wip[p] = d;
         4'b1100: if (wp_n) m_dr[p][r] = d;
         4'b1101: m_wip[p] = m_dr[p][r];
         4'b1110: if (wp_n) m_dr[p][r] = m_wip[p];
         4'b0001: for (int q = 0; q < 2; q++) m_wip[q] = m_dr[q][r];
         4'b1000: if (wp_n) for (int q = 0; q < 2; q++) m_dr[q][r] = m_wip[q];
         4'b0010: begin
            if (up && m_wip[p] != 8'hFF) m_wip[p] = m_wip[p] + 8'd1;
            else if (!up && m_wip[p] != 8'h00) m_wip[p] = m_wip[p] - 8'd1;
         end
         default: ;
      endcase
   endtask

   task automatic send(input logic [3:0] op, input int r, input int p,
                       input logic [7:0] d, input logic up);
      @(negedge clk);
      cmd_op = op; cmd_reg = 2'(r); cmd_pot = 1'(p); cmd_data = d; cmd_up = up;
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic exec(input logic [3:0] op, input int r, input int p,
                       input logic [7:0] d, input logic up);
      send(op, r, p, d, up);
      apply(op, r, p, d, up);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic check_wipers(input string tag);
      chk({tag, " wiper0"}, 32'(wiper_code[7:0]), 32'(m_wip[0]));
      chk({tag, " wiper1"}, 32'(wiper_code[15:8]), 32'(m_wip[1]));
   endtask

   task automatic check_drs(input string tag);
      for (int p = 0; p < 2; p++) begin
         for (int r = 0; r < 4; r++) begin
            wait_idle();
            send(4'b1011, r, p, 8'h00, 1'b0);
            chk($sformatf("%s dr%0d.%0d valid", tag, p, r), 32'(rd_valid), 32'd1);
            chk($sformatf("%s dr%0d.%0d data", tag, p, r), 32'(rd_data), 32'(m_dr[p][r]));
         end
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
   end

   initial begin : main
      int cnt;
      logic [7:0] vals [4];
      vals[0] = 8'h00; vals[1] = 8'h5A; vals[2] = 8'hFF; vals[3] = 8'h81;
      for (int p = 0; p < 2; p++)
         for (int r = 0; r < 4; r++)
            m_dr[p][r] = DRI[(p*4 + r)*8 +: 8];
      m_wip[0] = m_dr[0][0];
      m_wip[1] = m_dr[1][0];

      repeat (3) @(negedge clk);
      check_wipers("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_wipers("R1 after reset");
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 rd_valid", 32'(rd_valid), 32'd0);

      check_drs("R3 initial");
      for (int p = 0; p < 2; p++) begin
         send(4'b1001, 0, p, 8'h00, 1'b0);
         chk("R3 wiper read valid", 32'(rd_valid), 32'd1);
         chk("R3 wiper read data", 32'(rd_data), 32'(m_wip[p]));
      end

      // R2 sweep
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < 4; i++) begin
            exec(4'b1010, 0, p, vals[i] ^ 8'(p), 1'b0);
            check_wipers("R2 write wiper");
            chk("R2 no busy", 32'(busy), 32'd0);
         end
      end

      // R7 stepping with saturation
      exec(4'b1010, 0, 0, 8'hFD, 1'b0);
      for (int i = 0; i < 4; i++) begin
         exec(4'b0010, 0, 0, 8'h00, 1'b1);
         chk("R7 step up", 32'(wiper_code[7:0]), (i < 2) ? 32'(8'hFE + i) : 32'hFF);
      end
      exec(4'b1010, 0, 0, 8'h02, 1'b0);
      for (int i = 0; i < 4; i++) begin
         exec(4'b0010, 0, 0, 8'h00, 1'b0);
         chk("R7 step down", 32'(wiper_code[7:0]), (i < 2) ? 32'(8'h01 - i) : 32'h00);
      end
      check_wipers("R7 other pot untouched");

      // R4 / R9 data register write and busy length
      exec(4'b1100, 2, 1, 8'h3C, 1'b0);
      cnt = 0;
      while (busy && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
      chk("R9 busy length", 32'(cnt), 32'(NV));
      check_drs("R4 write dr");

      // R10 commands while busy are dropped
      exec(4'b1100, 3, 0, 8'h77, 1'b0);
      chk("R10 busy up", 32'(busy), 32'd1);
      send(4'b1010, 0, 0, 8'h11, 1'b0);
      check_wipers("R10 wiper write dropped");
      send(4'b1001, 0, 0, 8'h00, 1'b0);
      chk("R10 read dropped", 32'(rd_valid), 32'd0);
      send(4'b1100, 1, 0, 8'h99, 1'b0);
      wait_idle();
      check_drs("R10 dr write dropped");

      // R8 write protect
      wp_n = 1'b0;
      exec(4'b1100, 1, 0, 8'h11, 1'b0);
      chk("R8 no busy wr", 32'(busy), 32'd0);
      exec(4'b1110, 0, 1, 8'h00, 1'b0);
      chk("R8 no busy xfr", 32'(busy), 32'd0);
      exec(4'b1000, 2, 0, 8'h00, 1'b0);
      chk("R8 no busy global", 32'(busy), 32'd0);
      check_drs("R8 protected");
      wp_n = 1'b1;

      // R5 transfers into wipers
      exec(4'b1101, 3, 0, 8'h00, 1'b0);
      check_wipers("R5 single dr->wiper");
      chk("R5 no busy", 32'(busy), 32'd0);
      exec(4'b1101, 1, 1, 8'h00, 1'b0);
      check_wipers("R5 single dr->wiper pot1");
      exec(4'b0001, 2, 1, 8'h00, 1'b0);
      check_wipers("R5 global dr->wiper");

      // R6 transfers into data registers
      exec(4'b1010, 0, 0, 8'h5C, 1'b0);
      exec(4'b1010, 0, 1, 8'hC5, 1'b0);
      exec(4'b1110, 1, 1, 8'h00, 1'b0);
      chk("R6 busy single", 32'(busy), 32'd1);
      wait_idle();
      check_drs("R6 single wiper->dr");
      exec(4'b1010, 0, 0, 8'h6D, 1'b0);
      exec(4'b1000, 0, 1, 8'h00, 1'b0);
      wait_idle();
      check_drs("R6 global wiper->dr");

      // R1 recall of rewritten register 0
      exec(4'b1010, 0, 0, 8'h00, 1'b0);
      exec(4'b1010, 0, 1, 8'h00, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_wip[0] = m_dr[0][0];
      m_wip[1] = m_dr[1][0];
      @(negedge clk);
      check_wipers("R1 recall");

      // R11 unknown opcodes
      for (int i = 0; i < 3; i++) begin
         logic [3:0] op;
         op = (i == 0) ? 4'hF : (i == 1) ? 4'h0 : 4'h3;
         send(op, 1, 0, 8'h42, 1'b1);
         chk("R11 no busy", 32'(busy), 32'd0);
         chk("R11 no read", 32'(rd_valid), 32'd0);
         check_wipers("R11 wipers");
      end
      check_drs("R11 drs");

      summary();
      $finish;
   end

endmodule